// File: doc/BRIEF.md
# Pulse-Position Forward Link Encoder

This block turns a short bit sequence into on/off gating of a low-frequency reader field, so that a reader can send a command to a tag. All durations are counted in carrier cycles. One carrier cycle is 8 µs at 125 kHz, and the block is told about each one by a single-clock tick enable. The caller loads a bit vector and a count of valid bits, then pulses a start strobe. While it encodes, the block holds busy high. When the last bit cell ends, it pulses done for one clock.

The first element of the sequence is not encoded. A fixed start pattern is sent in its place: the field goes off for 55 cycles and then comes back on for 16. Every later bit fills a 32-cycle cell. A one leaves the field on for the whole cell. A zero cuts the field for 23 cycles, then restores it for the remaining 9. Bits are taken in ascending index order. Only the field gating is produced here. Building the command bits, protecting them with a CRC and capturing the tag response are left to other blocks.

Top module: `ppm_fwd_enc`

## Requirements
- R1: Out of reset, field_on_o is 1 and busy_o and done_o are 0. The field stays on whenever busy_o is low.
- R2: A start_i pulse while idle raises busy_o and drops field_on_o at the next clock. The field then stays off for exactly 55 ticks and on for exactly 16 ticks.
- R3: Element 0 of bits_i is never encoded. Elements 1 up to count-1 are encoded, one cell each, in ascending index order.
- R4: An encoded bit of value 1 keeps field_on_o at 1 for 32 ticks.
- R5: An encoded bit of value 0 drives field_on_o to 0 for 23 ticks and then to 1 for 9 ticks.
- R6: The clock after the final tick of the last cell, done_o is 1 for exactly one clock. In that same clock busy_o is 0 and field_on_o is 1.
- R7: While busy_o is high, start_i has no effect, and changes on bits_i and nbits_i have no effect. The frame in progress uses the values captured at start.
- R8: A bit count of 0 or 1 sends only the start pattern, so the frame lasts 71 ticks.
- R9: A bit count larger than MAX_BITS is treated as MAX_BITS.
- R10: Timing advances only on clocks where tick_i is 1. With tick_i held low, field_on_o and busy_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock enable per carrier cycle |
| start_i | input | 1 | Start strobe; accepted only while idle |
| bits_i | input | MAX_BITS | Bit sequence, element 0 first |
| nbits_i | input | $clog2(MAX_BITS+1) | Number of valid elements in bits_i |
| field_on_o | output | 1 | 1 = reader field on, 0 = field off |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock pulse at frame end |

## Verification
A fault in the phase counter shifts a field edge by one or more ticks. That error appears on field_on_o at the tick where the edge should have been, and every edge after it moves too. A wrong bit index or a wrong captured value swaps a 32-tick on run for a 23-tick notch, or the reverse, within the cell that holds it. A fault in the end-of-frame decision changes how many ticks pass before done_o, so it shows only at the end of the frame. For that reason the bench compares the complete tick-by-tick field trace and its length.

// File: rtl/ppm_fwd_pkg.sv
package ppm_fwd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SOFF  = 3'd1,
    PH_SON   = 3'd2,
    PH_ZOFF  = 3'd3,
    PH_ZON   = 3'd4,
    PH_ONE   = 3'd5
  } phase_e;

  function automatic logic phase_is_off(phase_e p);
    return (p == PH_SOFF) || (p == PH_ZOFF);
  endfunction
endpackage

// File: rtl/ppm_tick_timer.sv
module ppm_tick_timer #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = tick_i && (cnt_q == len_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/ppm_bit_pick.sv
module ppm_bit_pick #(
  parameter int N  = 64,
  parameter int IW = 7
) (
  input  logic [N-1:0]  bits_i,
  input  logic [IW-1:0] idx_i,
  output logic          bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < N; i++)
      if (idx_i == IW'(i)) bit_o = bits_i[i];
  end
endmodule

// File: rtl/ppm_fwd_enc.sv
module ppm_fwd_enc
  import ppm_fwd_pkg::*;
#(
  parameter int MAX_BITS  = 64,
  parameter int START_OFF = 55,
  parameter int START_ON  = 16,
  parameter int CELL      = 32,
  parameter int ZERO_OFF  = 23,
  parameter int IDX_W     = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                start_i,
  input  logic [MAX_BITS-1:0] bits_i,
  input  logic [IDX_W-1:0]    nbits_i,
  output logic                field_on_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int ZERO_ON = CELL - ZERO_OFF;
  localparam int MAX_A   = (START_OFF > START_ON) ? START_OFF : START_ON;
  localparam int MAX_LEN = (MAX_A > CELL) ? MAX_A : CELL;
  localparam int CW      = $clog2(MAX_LEN + 1);

  phase_e              ph_q, ph_d;
  logic [MAX_BITS-1:0] bits_q;
  logic [IDX_W-1:0]    nbits_q, idx_q;
  logic                done_q;
  logic [CW-1:0]       len;
  logic                last, cur_bit, accept, more;

  assign accept = start_i && (ph_q == PH_IDLE);
  assign more   = idx_q < nbits_q;

  always_comb begin
    unique case (ph_q)
      PH_SOFF: len = CW'(START_OFF);
      PH_SON:  len = CW'(START_ON);
      PH_ZOFF: len = CW'(ZERO_OFF);
      PH_ZON:  len = CW'(ZERO_ON);
      PH_ONE:  len = CW'(CELL);
      default: len = CW'(1);
    endcase
  end

  ppm_tick_timer #(.CW(CW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .tick_i (tick_i && (ph_q != PH_IDLE)),
    .len_i  (len),
    .last_o (last)
  );

  ppm_bit_pick #(.N(MAX_BITS), .IW(IDX_W)) u_pick (
    .bits_i (bits_q),
    .idx_i  (idx_q),
    .bit_o  (cur_bit)
  );

  always_comb begin
    ph_d = ph_q;
    if (accept) ph_d = PH_SOFF;
    else if (last) begin
      unique case (ph_q)
        PH_SOFF: ph_d = PH_SON;
        PH_ZOFF: ph_d = PH_ZON;
        PH_SON, PH_ZON, PH_ONE:
          ph_d = !more ? PH_IDLE : (cur_bit ? PH_ONE : PH_ZOFF);
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      bits_q  <= '0;
      nbits_q <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= 1'b0;
      if (accept) begin
        bits_q  <= bits_i;
        nbits_q <= (nbits_i > IDX_W'(MAX_BITS)) ? IDX_W'(MAX_BITS) : nbits_i;
        idx_q   <= IDX_W'(1);  // element 0 replaced by start pattern
      end else if (last && (ph_q == PH_SON || ph_q == PH_ZON || ph_q == PH_ONE)) begin
        if (more) idx_q <= idx_q + IDX_W'(1);
        else      done_q <= 1'b1;
      end
    end
  end

  assign field_on_o = !phase_is_off(ph_q);
  assign busy_o     = (ph_q != PH_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/ppm_fwd_enc_chk.sv
module ppm_fwd_enc_chk #(
  parameter int START_OFF = 55
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic start_i,
  input logic field_on_o,
  input logic busy_o,
  input logic done_o
);
  int off_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          off_run <= 0;
    else if (field_on_o)  off_run <= 0;
    else if (tick_i)      off_run <= off_run + 1;
  end

  p_idle_field_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> field_on_o);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !field_on_o));
  p_off_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_run <= START_OFF);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && field_on_o && $past(busy_o)));
  p_hold_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> busy_o);
  p_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> $stable(field_on_o));
endmodule

bind ppm_fwd_enc ppm_fwd_enc_chk #(.START_OFF(START_OFF)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .start_i    (start_i),
  .field_on_o (field_on_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sim_ppm_fwd_enc.sv
`timescale 1ns/1ps
module sim_ppm_fwd_enc;
  localparam int MB = 64;
  localparam int IW = $clog2(MB + 1);

  logic clk = 0, rst_ni = 0, tick_i = 0, start_i = 0;
  logic [MB-1:0] bits_i = '0;
  logic [IW-1:0] nbits_i = '0;
  logic field_on_o, busy_o, done_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic exp_f [0:4095];
  int   exp_len;

  always #5 clk = ~clk;

  ppm_fwd_enc u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .bits_i(bits_i), .nbits_i(nbits_i),
    .field_on_o(field_on_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic push(logic v, int k);
    for (int i = 0; i < k; i++) begin exp_f[exp_len] = v; exp_len++; end
  endtask

  task automatic build(logic [MB-1:0] b, int n);
    int e;
    e = (n > MB) ? MB : n;
    exp_len = 0;
    push(1'b0, 55); push(1'b1, 16);
    for (int i = 1; i < e; i++) begin
      if (b[i]) push(1'b1, 32);
      else begin push(1'b0, 23); push(1'b1, 9); end
    end
  endtask

  task automatic launch(logic [MB-1:0] b, int n);
    @(negedge clk);
    bits_i = b; nbits_i = IW'(n); start_i = 1; tick_i = 0;
    @(negedge clk);
    start_i = 0;
  endtask

  // collects the field trace, one sample per tick, until done
  task automatic collect(string req, int tper, bit disturb);
    int slots = 0, bad = 0, ph = 0, guard = 0, busy_bad = 0;
    while (!done_o && guard < 30000) begin
      guard++;
      tick_i = (ph == 0);
      if (tick_i) begin
        if (slots < exp_len && field_on_o !== exp_f[slots]) bad++;
        if (!busy_o) busy_bad++;
        slots++;
      end
      if (disturb && slots == 200) begin
        start_i = 1; bits_i = ~bits_i; nbits_i = IW'(3);
      end else start_i = 0;
      ph = (ph + 1) % tper;
      @(negedge clk);
    end
    tick_i = 0; start_i = 0;
    chk({req, " trace length"}, slots, exp_len);
    chk({req, " trace mismatches"}, bad, 0);
    chk({req, " busy during frame"}, busy_bad, 0);
    chk({"R6 done with busy low"}, busy_o, 0);
    chk({"R6 field on at end"}, field_on_o, 1);
    @(negedge clk);
    chk({"R6 done one clock"}, done_o, 0);
  endtask

  task automatic t_reset;
    chk("R1 reset field", field_on_o, 1);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset done", done_o, 0);
  endtask

  task automatic t_frame(string req, logic [MB-1:0] b, int n, int tper);
    build(b, n);
    launch(b, n);
    chk("R2 busy after start", busy_o, 1);
    chk("R2 field off after start", field_on_o, 0);
    collect(req, tper, 0);
  endtask

  task automatic t_busy_start;
    logic [MB-1:0] b = 64'h0000_0000_0000_36C5;
    build(b, 16);
    launch(b, 16);
    collect("R7 start and inputs ignored while busy", 1, 1);
  endtask

  task automatic t_stall;
    logic [MB-1:0] b = 64'h0000_0000_0000_00B2;
    int moved = 0;
    build(b, 8);
    launch(b, 8);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (field_on_o !== 1'b0 || busy_o !== 1'b1) moved++;
    end
    chk("R10 no tick holds outputs", moved, 0);
    collect("R10 trace after stall", 2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_frame("R8 count zero", 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
    t_frame("R8 count one", 64'h1, 1, 2);
    t_frame("R3 R4 R5 mixed", 64'h0000_0000_0000_00A5, 8, 3);
    t_frame("R3 element 0 ignored", 64'h0000_0000_0000_00A4, 8, 1);
    t_frame("R4 all ones", 64'h0000_0000_0000_FFFF, 16, 1);
    t_frame("R5 all zeros", 64'h0, 10, 2);
    t_frame("R3 full length", 64'hC3A5_0F1E_9B72_D846, 64, 1);
    t_frame("R9 count clamp", 64'h8421_1248_F0F0_5A5A, 100, 1);
    t_busy_start();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule